// File: doc/BRIEF.md
# Trigger-Latched Six-Channel PWM Controller

The block generates six independent pulse-width waveforms from a single clock. Software programs each channel through a small word-addressed register file: a 3-bit prescaler, a 24-bit period count, a 24-bit high-time count, a polarity bit, a drive-type bit and a smooth-update bit. All of these writes land in staged registers. A channel's waveform generator only changes when software produces a rising edge on that channel's trigger bit.

At the rising edge the staged configuration is copied into a per-channel shadow set. With the smooth bit clear, the shadow set becomes active two clocks after the trigger write and the period restarts from zero. With the smooth bit set, the shadow set becomes active at the next period boundary, so the running period is never cut short. There is no enable control. A channel whose trigger and smooth bits are both low drives a constant high level. Writing a zero high-time count and triggering gives the idle level.

Top module: `trig_pwm_top`

## Requirements
- R1: After reset every register reads zero, every `pwm_o` bit is 1 and every `oe_o` bit is 0.
- R2: Register words are selected by byte address: control 0x00, prescale 0x04, period of channel n at 0x08+8n, high time of channel n at 0x0C+8n. In the control word, channel n has trigger at bit n, polarity at bit 8+n, drive type at bit 16+n and smooth at bit 24+n. In the prescale word, channel n has a 3-bit field at bit 4n. Counts occupy bits 23:0. Reads return the staged values with all undefined bits at zero. Any other address, and any address with bits 1:0 not zero, reads zero and is not written.
- R3: With prescale p, period count PC ≥ 2 and high count DC, the waveform repeats every (p+1)·PC clocks. Its first (p+1)·min(DC,PC) clocks are active and the rest are inactive. DC ≥ PC keeps the active level for the whole period.
- R4: Polarity 1 drives the active portion as 1 and the rest as 0. Polarity 0 inverts the output.
- R5: Writes to prescale, period, high time and polarity do not change the output until a later 0-to-1 transition of that channel's trigger bit. A control write that leaves the trigger bit at 1 is not such a transition.
- R6: With smooth clear at the trigger's rising edge, the new settings drive the output two clocks after the clock edge that wrote the trigger bit, starting at phase zero.
- R7: With smooth set at the trigger's rising edge, the running waveform completes its current period. The new settings take over at phase zero from the first period boundary at least two clocks after the trigger write.
- R8: While a channel's trigger and smooth bits are both 0, its output is 1. When either bit is 1, the active waveform continues at the phase it would have reached, because the counters keep running during the hold.
- R9: Drive type 1 gives `oe_o` = 1. Drive type 0 gives `oe_o` = 1 only while `pwm_o` is 0.
- R10: Programming or triggering one channel does not alter another channel's waveform.
- R11: A high count of 0 with polarity 1 gives a constant 0 output for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from `addr_i` |
| pwm_o | output | NUM_CH | Per-channel waveform |
| oe_o | output | NUM_CH | Per-channel pad drive enable |

## Verification
The property checks assume that software never programs a period count below 2 into a channel it triggers. Below 2 the period counter has no meaningful bound. They also assume that the trigger bit only rises through a control write, which is the only path available. The stimulus respects both assumptions. Every triggered configuration in the sweeps uses a period of 2 or more. The only write of 0 period counts is the readback test, and it leaves the count bound check disabled. Each trigger rise comes from a deliberate control write that first lowers the bit with smooth set, so the hold-high window is never crossed unintentionally.

// File: rtl/trig_pwm_pkg.sv
`timescale 1ns/1ps
package trig_pwm_pkg;
  localparam int unsigned CNT_W = 24;
  localparam int unsigned PSC_W = 3;

  // control word lane bases (channel index added)
  localparam int unsigned LANE_TRIG   = 0;
  localparam int unsigned LANE_POL    = 8;
  localparam int unsigned LANE_TYPE   = 16;
  localparam int unsigned LANE_SMOOTH = 24;
  localparam int unsigned PSC_STRIDE  = 4;

  // word indices (byte address >> 2)
  localparam int unsigned WI_CTRL   = 0;
  localparam int unsigned WI_PSC    = 1;
  localparam int unsigned WI_CH0_PC = 2;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] pc;
    logic [CNT_W-1:0] dc;
    logic             pol;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RST = '{psc: '0, pc: '0, dc: '0, pol: 1'b1};
endpackage

// File: rtl/trig_pwm_regs.sv
`timescale 1ns/1ps
module trig_pwm_regs
  import trig_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_CH-1:0]             trig_o,
  output logic [NUM_CH-1:0]             pol_o,
  output logic [NUM_CH-1:0]             type_o,
  output logic [NUM_CH-1:0]             smooth_o,
  output logic [NUM_CH-1:0][PSC_W-1:0]  psc_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  pc_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  dc_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              wr;
  logic              unused_wdata;

  assign widx         = addr_i[ADDR_W-1:2];
  assign aligned      = (addr_i[1:0] == 2'b00);
  assign wr           = req_i & we_i & aligned;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o   <= '0;
      pol_o    <= '0;
      type_o   <= '0;
      smooth_o <= '0;
      psc_o    <= '0;
      pc_o     <= '0;
      dc_o     <= '0;
    end else if (wr) begin
      if (widx == WIDX_W'(WI_CTRL)) begin
        for (int c = 0; c < NUM_CH; c++) begin
          trig_o[c]   <= wdata_i[LANE_TRIG + c];
          pol_o[c]    <= wdata_i[LANE_POL + c];
          type_o[c]   <= wdata_i[LANE_TYPE + c];
          smooth_o[c] <= wdata_i[LANE_SMOOTH + c];
        end
      end
      if (widx == WIDX_W'(WI_PSC)) begin
        for (int c = 0; c < NUM_CH; c++)
          psc_o[c] <= wdata_i[PSC_STRIDE*c +: PSC_W];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (widx == WIDX_W'(WI_CH0_PC + 2*c))     pc_o[c] <= wdata_i[CNT_W-1:0];
        if (widx == WIDX_W'(WI_CH0_PC + 2*c + 1)) dc_o[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (widx == WIDX_W'(WI_CTRL)) begin
        for (int c = 0; c < NUM_CH; c++) begin
          rdata_o[LANE_TRIG + c]   = trig_o[c];
          rdata_o[LANE_POL + c]    = pol_o[c];
          rdata_o[LANE_TYPE + c]   = type_o[c];
          rdata_o[LANE_SMOOTH + c] = smooth_o[c];
        end
      end
      if (widx == WIDX_W'(WI_PSC)) begin
        for (int c = 0; c < NUM_CH; c++)
          rdata_o[PSC_STRIDE*c +: PSC_W] = psc_o[c];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (widx == WIDX_W'(WI_CH0_PC + 2*c))     rdata_o[CNT_W-1:0] = pc_o[c];
        if (widx == WIDX_W'(WI_CH0_PC + 2*c + 1)) rdata_o[CNT_W-1:0] = dc_o[c];
      end
    end
  end
endmodule

// File: rtl/trig_pwm_chan.sv
`timescale 1ns/1ps
module trig_pwm_chan
  import trig_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             smooth_i,
  input  logic             type_i,
  input  chan_cfg_t        stg_i,
  output logic             pwm_o,
  output logic             oe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pc_act_o
);
  chan_cfg_t        shd_q, act_q;
  logic             trig_q;
  logic             imm_pend_q, smo_pend_q;
  logic [PSC_W-1:0] pcnt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, tick, wrap, boundary, apply;
  logic             active, wave;

  assign rise     = trig_i & ~trig_q;
  assign tick     = (pcnt_q == act_q.psc);
  // compare one bit wider so a period count of 0 or 1 wraps every tick
  assign wrap     = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, act_q.pc};
  assign boundary = tick & wrap;
  assign apply    = imm_pend_q | (smo_pend_q & boundary);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q     <= 1'b0;
      shd_q      <= CFG_RST;
      act_q      <= CFG_RST;
      imm_pend_q <= 1'b0;
      smo_pend_q <= 1'b0;
      pcnt_q     <= '0;
      cnt_q      <= '0;
    end else begin
      trig_q <= trig_i;
      if (rise) begin
        shd_q      <= stg_i;
        imm_pend_q <= ~smooth_i;
        smo_pend_q <= smooth_i;
      end else if (apply) begin
        imm_pend_q <= 1'b0;
        smo_pend_q <= 1'b0;
      end
      if (apply) begin
        act_q  <= shd_q;
        pcnt_q <= '0;
        cnt_q  <= '0;
      end else if (tick) begin
        pcnt_q <= '0;
        cnt_q  <= wrap ? '0 : cnt_q + CNT_W'(1);
      end else begin
        pcnt_q <= pcnt_q + PSC_W'(1);
      end
    end
  end

  assign active   = (cnt_q < act_q.dc);
  assign wave     = act_q.pol ? active : ~active;
  assign pwm_o    = (~trig_i & ~smooth_i) ? 1'b1 : wave;
  assign oe_o     = type_i | ~pwm_o;
  assign cnt_o    = cnt_q;
  assign pc_act_o = act_q.pc;
endmodule

// File: rtl/trig_pwm_top.sv
`timescale 1ns/1ps
module trig_pwm_top
  import trig_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] oe_o
);
  logic [NUM_CH-1:0]            trig_w, pol_w, type_w, smooth_w;
  logic [NUM_CH-1:0][PSC_W-1:0] psc_w;
  logic [NUM_CH-1:0][CNT_W-1:0] pc_w, dc_w;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, pc_act_w;

  trig_pwm_regs #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .trig_o  (trig_w),
    .pol_o   (pol_w),
    .type_o  (type_w),
    .smooth_o(smooth_w),
    .psc_o   (psc_w),
    .pc_o    (pc_w),
    .dc_o    (dc_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t stg;
    assign stg = '{psc: psc_w[c], pc: pc_w[c], dc: dc_w[c], pol: pol_w[c]};

    trig_pwm_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig_w[c]),
      .smooth_i(smooth_w[c]),
      .type_i  (type_w[c]),
      .stg_i   (stg),
      .pwm_o   (pwm_o[c]),
      .oe_o    (oe_o[c]),
      .cnt_o   (cnt_w[c]),
      .pc_act_o(pc_act_w[c])
    );
  end
endmodule

// File: rtl/trig_pwm_chk.sv
`timescale 1ns/1ps
module trig_pwm_chk
  import trig_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 6
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CH-1:0]             trig_i,
  input logic [NUM_CH-1:0]             smooth_i,
  input logic [NUM_CH-1:0]             pwm_i,
  input logic [NUM_CH-1:0]             oe_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]  pc_act_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8
    hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig_i[c] && !smooth_i[c]) |-> pwm_i[c]);

    // R9
    low_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_i[c] |-> oe_i[c]);

    // R6
    imm_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(trig_i[c]) && !smooth_i[c]) |=> ##1 (cnt_i[c] == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pc_act_i[c] >= CNT_W'(2)) |-> (cnt_i[c] < pc_act_i[c]));
  end
endmodule

bind trig_pwm_top trig_pwm_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_w),
  .smooth_i(smooth_w),
  .pwm_i   (pwm_o),
  .oe_i    (oe_o),
  .cnt_i   (cnt_w),
  .pc_act_i(pc_act_w)
);

// File: tb/trig_pwm_top_tb.sv
`timescale 1ns/1ps
module trig_pwm_top_tb;
  localparam int NCH = 6;

  typedef struct {
    int psc;
    int pc;
    int dc;
    bit pol;
  } wcfg_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req = 1'b0;
  logic           we = 1'b0;
  logic [7:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NCH-1:0] pwm, oe;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] ctrl_sh = '0;
  logic [31:0] psc_sh = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_pwm_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
    req = 1'b0;
  endtask

  function automatic logic exp_wave(input wcfg_t w, input int j);
    int ph;
    logic act;
    ph  = (j / (w.psc + 1)) % w.pc;
    act = (ph < w.dc);
    return w.pol ? act : !act;
  endfunction

  // stage a config, then fall/rise the trigger with smooth clear; returns phase-zero cycle
  task automatic apply_imm(input int ch, input wcfg_t w, output int start);
    psc_sh[4*ch +: 3] = w.psc[2:0];
    bus_wr(8'h04, psc_sh);
    bus_wr(8'(8'h08 + 8*ch), 32'(w.pc));
    bus_wr(8'(8'h0C + 8*ch), 32'(w.dc));
    ctrl_sh[8+ch]  = w.pol;
    ctrl_sh[24+ch] = 1'b1;
    ctrl_sh[ch]    = 1'b0;
    bus_wr(8'h00, ctrl_sh);
    ctrl_sh[24+ch] = 1'b0;
    ctrl_sh[ch]    = 1'b1;
    bus_wr(8'h00, ctrl_sh);
    start = cyc + 2;
  endtask

  // compare pwm[ch] with config a (phase from sa) until cycle sw, then config b (phase from sw)
  task automatic check_seq(input int ch, input wcfg_t a, input int sa, input wcfg_t b,
                           input int sw, input int len, input string tag);
    int bad = 0;
    logic fa = 1'b0, fe = 1'b0;
    while (cyc < sa) @(negedge clk);
    for (int k = 0; k < len; k++) begin
      logic e;
      e = (cyc < sw) ? exp_wave(a, cyc - sa) : exp_wave(b, cyc - sw);
      if (pwm[ch] !== e) begin
        if (bad == 0) begin fa = pwm[ch]; fe = e; end
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, tag, fa, fe);
  endtask

  task automatic sweep(input int ch, input int psc_lo, input int psc_hi);
    int pcs[3] = '{2, 3, 5};
    for (int p = psc_lo; p <= psc_hi; p++) begin
      for (int ip = 0; ip < 3; ip++) begin
        for (int id = 0; id < 5; id++) begin
          for (int pl = 0; pl < 2; pl++) begin
            wcfg_t w;
            int s, per;
            string tag;
            w.psc = p; w.pc = pcs[ip]; w.pol = pl[0];
            case (id)
              0: w.dc = 0;
              1: w.dc = 1;
              2: w.dc = w.pc - 1;
              3: w.dc = w.pc;
              default: w.dc = w.pc + 1;
            endcase
            if (w.dc == 0 && w.pol) tag = "R11";
            else if (!w.pol) tag = "R4";
            else tag = "R3";
            apply_imm(ch, w, s);
            per = (p + 1) * w.pc;
            check_seq(ch, w, s, w, 1 << 30, 2*per + 3, tag);
          end
        end
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    wcfg_t a, b, x, y;
    int sa, sb, t, sw, per_a, len;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pwm === 6'h3F, "R1 pwm", pwm, 6'h3F);
    chk(oe === 6'h00, "R1 oe", oe, 0);
    bus_rd_chk(8'h00, 32'h0, "R1 ctrl");
    bus_rd_chk(8'h0C, 32'h0, "R1 dc0");

    // R2 register map and readback
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd_chk(8'h00, 32'h3F3F_3F3F, "R2 ctrl");
    bus_wr(8'h00, 32'h0);
    bus_rd_chk(8'h00, 32'h0, "R2 ctrl clr");
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd_chk(8'h04, 32'h0077_7777, "R2 psc");
    bus_wr(8'h04, 32'h0);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd_chk(8'h20, 32'h00FF_FFFF, "R2 pc3");
    bus_wr(8'h34, 32'h1234_5678);
    bus_rd_chk(8'h34, 32'h0034_5678, "R2 dc5");
    bus_wr(8'h38, 32'hFFFF_FFFF);
    bus_rd_chk(8'h38, 32'h0, "R2 unmapped");
    bus_wr(8'h09, 32'h55);
    bus_rd_chk(8'h08, 32'h0, "R2 unaligned write");
    bus_rd_chk(8'h22, 32'h0, "R2 unaligned read");
    bus_wr(8'h20, 32'h0);
    bus_wr(8'h34, 32'h0);
    chk(pwm === 6'h3F, "R8 hold after clr", pwm, 6'h3F);

    // R3 R4 R11 sweeps
    sweep(0, 0, 2);
    sweep(5, 6, 7);

    // R6 latency: constant low -> constant high
    a = '{psc: 0, pc: 4, dc: 0, pol: 1'b1};
    apply_imm(1, a, sa);
    repeat (6) @(negedge clk);
    chk(pwm[1] === 1'b0, "R11 idle", pwm[1], 0);
    bus_wr(8'h14, 32'd4);
    ctrl_sh[25] = 1'b1; ctrl_sh[1] = 1'b0;
    bus_wr(8'h00, ctrl_sh);
    ctrl_sh[25] = 1'b0; ctrl_sh[1] = 1'b1;
    bus_wr(8'h00, ctrl_sh);
    chk(pwm[1] === 1'b0, "R6 t+0", pwm[1], 0);
    @(negedge clk);
    chk(pwm[1] === 1'b0, "R6 t+1", pwm[1], 0);
    @(negedge clk);
    chk(pwm[1] === 1'b1, "R6 t+2", pwm[1], 1);

    // R5 staged writes without a rising trigger
    a = '{psc: 1, pc: 5, dc: 2, pol: 1'b1};
    apply_imm(3, a, sa);
    psc_sh[14:12] = 3'd0;
    bus_wr(8'h04, psc_sh);
    bus_wr(8'h20, 32'd3);
    bus_wr(8'h24, 32'd1);
    ctrl_sh[11] = 1'b0;
    bus_wr(8'h00, ctrl_sh);
    check_seq(3, a, sa, a, 1 << 30, 40, "R5");

    // R8 hold high, then resume
    ctrl_sh[3] = 1'b0; ctrl_sh[27] = 1'b0;
    bus_wr(8'h00, ctrl_sh);
    begin
      int bad = 0;
      for (int k = 0; k < 20; k++) begin
        if (pwm[3] !== 1'b1) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 hold", bad, 0);
    end
    ctrl_sh[27] = 1'b1;
    bus_wr(8'h00, ctrl_sh);
    check_seq(3, a, sa, a, 1 << 30, 20, "R8 resume");

    // R7 smooth switch at period boundary
    b = '{psc: 0, pc: 3, dc: 1, pol: 1'b0};
    ctrl_sh[3] = 1'b1;
    bus_wr(8'h00, ctrl_sh);
    t = cyc;
    per_a = (a.psc + 1) * a.pc;
    sw = sa + per_a * ((t + 2 - sa + per_a - 1) / per_a);
    len = sw - cyc + 20;
    check_seq(3, a, sa, b, sw, len, "R7");

    // R10 independence
    x = '{psc: 1, pc: 3, dc: 1, pol: 1'b1};
    apply_imm(2, x, sb);
    y = '{psc: 0, pc: 6, dc: 3, pol: 1'b0};
    apply_imm(4, y, sa);
    check_seq(2, x, sb, x, 1 << 30, 40, "R10 ch2");
    check_seq(4, y, sa, y, 1 << 30, 24, "R10 ch4");

    // R9 drive type
    ctrl_sh[18] = 1'b1;
    bus_wr(8'h00, ctrl_sh);
    begin
      int bad = 0;
      for (int k = 0; k < 20; k++) begin
        if (oe[2] !== 1'b1) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R9 push-pull", bad, 0);
    end
    ctrl_sh[18] = 1'b0;
    bus_wr(8'h00, ctrl_sh);
    begin
      int bad = 0;
      int lows = 0;
      for (int k = 0; k < 20; k++) begin
        if (oe[2] !== ~pwm[2]) bad++;
        if (pwm[2] === 1'b0) lows++;
        @(negedge clk);
      end
      chk(bad == 0 && lows > 0, "R9 low-only", bad, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule